// File: doc/BRIEF.md
# Synchronous Serial Master Engine

This block moves one byte at a time over a three-wire synchronous serial link, and it always acts as the clock master. A periodic one-cycle timer tick drives a 4-bit counter that divides it by sixteen. The divided clock leaves the block on `sclk_o`. Software selects which directions are allowed with a control register and loads the shared data register. It then sets a trigger bit to start either a transmission on `sout_o` or a reception from `sin_i`. Bits go least significant first. Each direction has its own one-cycle completion pulse.

The engine is a five-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Nothing is in progress. |
| `ST_TX_HI` | Transmit, clock-high half period. |
| `ST_TX_LO` | Transmit, clock-low half period. |
| `ST_RX_HI` | Receive, clock-high half period. |
| `ST_RX_LO` | Receive, clock-low half period. |

The transitions are:

- **start-tx:** `ST_IDLE` to `ST_TX_HI`, on an accepted transmit trigger.
- **start-rx:** `ST_IDLE` to `ST_RX_HI`, on an accepted receive trigger.
- **fall:** `ST_*_HI` to `ST_*_LO`, on the eighth tick of a bit period.
- **rise:** `ST_*_LO` to `ST_*_HI`, on the sixteenth tick of a bit period.
- **finish:** `ST_*_LO` to `ST_IDLE`, on the rising edge of the eighth bit.

While the block is idle the divide counter is held at zero. As a result, every transfer starts from the same phase.

Top module: `ssm_top`

## Requirements
- R1: After reset, `sclk_o` is 1, `sout_o` is 0, and both interrupt pulses are 0. The control, trigger and data registers all read 0.
- R2: The register map is as follows:
  - Address 0 is control: bit 0 enables transmit and bit 1 enables receive.
  - Address 1 is trigger: writing bit 0 as 1 starts a transmit and writing bit 1 as 1 starts a receive.
  - Address 2 is the data byte.
  - Other addresses read 0.
  - A trigger whose direction is not enabled is ignored.
- R3: `sclk_o` idles high. After a start, the divide counter begins at zero, so `sclk_o` falls on the 8th tick and rises on the 16th tick of each 16-tick bit period.
- R4: During a transmit, `sout_o` takes data bit n at the falling edge of bit period n, for n = 0 to 7. Bits go LSB first.
- R5: A transmit ends at the 8th rising edge. `tx_irq_o` pulses for exactly one clock in that cycle, and trigger bit 0 reads 0 from that cycle on. The data register then holds the byte that was sent.
- R6: During a receive, `sin_i` is sampled at each rising edge, LSB first. `rx_irq_o` pulses for one clock in the cycle that the 8th sample is taken, and the data register then holds the received byte.
- R7: Trigger bit 0 reads 1 while a transmit is in progress, and bit 1 reads 1 while a receive is in progress.
- R8: Writes to the trigger or data register during a transfer are ignored.
- R9: If both trigger bits are written as 1 with both directions enabled, only the transmit starts.
- R10: When no transfer is in progress, `sout_o` holds the last bit it drove.
- R11: Ticks that arrive while the block is idle have no effect on `sclk_o` or `sout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timer pulse |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| sin_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock out |
| sout_o | output | 1 | Serial data out |
| tx_irq_o | output | 1 | Transmit-complete pulse |
| rx_irq_o | output | 1 | Receive-complete pulse |

## Verification
The assertions check four properties on every cycle:
- The serial clock is high whenever the block is idle.
- The serial clock changes only after a tick, and `sout_o` changes only on a falling edge.
- Each completion pulse lasts one cycle and coincides with a rising edge and with the busy flag clearing.
- The two directions are never busy together.

Only the bench scenarios can show the rest:
- the exact bit values and their LSB-first order on `sout_o`;
- the assembled received byte;
- the 8th-tick and 16th-tick edge placement;
- that disabled triggers, writes made mid-transfer and idle ticks leave the state untouched.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TX_HI = 3'd1,
        ST_TX_LO = 3'd2,
        ST_RX_HI = 3'd3,
        ST_RX_LO = 3'd4
    } ssm_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TRIG = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int BIT_TX = 0;
    localparam int BIT_RX = 1;

endpackage

// File: rtl/ssm_clkdiv.sv
module ssm_clkdiv #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    output logic fall_evt,
    output logic rise_evt
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] HALF_LAST = CW'(DIV / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == FULL_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign fall_evt = tick && !hold && (cnt_q == HALF_LAST);
    assign rise_evt = tick && !hold && (cnt_q == FULL_LAST);

endmodule

// File: rtl/ssm_regif.sv
module ssm_regif #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    waddr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    raddr,
    output logic [DW-1:0] rdata,
    input  logic          tx_busy,
    input  logic          rx_busy,
    input  logic [DW-1:0] data_q,
    output logic          start_tx,
    output logic          start_rx,
    output logic          data_we
);
    import ssm_pkg::*;

    logic tx_en_q;
    logic rx_en_q;
    logic idle;
    logic trig_wr;

    assign idle    = !tx_busy && !rx_busy;
    assign trig_wr = we && (waddr == ADDR_TRIG) && idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
        end else if (we && (waddr == ADDR_CTRL)) begin
            tx_en_q <= wdata[BIT_TX];
            rx_en_q <= wdata[BIT_RX];
        end
    end

    assign start_tx = trig_wr && wdata[BIT_TX] && tx_en_q;
    assign start_rx = trig_wr && wdata[BIT_RX] && rx_en_q && !start_tx;
    assign data_we  = we && (waddr == ADDR_DATA) && idle;

    always_comb begin
        rdata = '0;
        unique case (raddr)
            ADDR_CTRL: begin
                rdata[BIT_TX] = tx_en_q;
                rdata[BIT_RX] = rx_en_q;
            end
            ADDR_TRIG: begin
                rdata[BIT_TX] = tx_busy;
                rdata[BIT_RX] = rx_busy;
            end
            ADDR_DATA: rdata = data_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/ssm_engine.sv
module ssm_engine #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_tx,
    input  logic          start_rx,
    input  logic          fall_evt,
    input  logic          rise_evt,
    input  logic          sin,
    input  logic          data_we,
    input  logic [DW-1:0] data_wdata,
    output logic [DW-1:0] data_q,
    output logic          tx_busy,
    output logic          rx_busy,
    output logic          div_hold,
    output logic          sclk,
    output logic          sout,
    output logic          tx_irq,
    output logic          rx_irq
);
    import ssm_pkg::*;

    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    ssm_state_t state_q, state_d;
    logic [BW-1:0] bit_q;
    logic          last;

    assign last     = (bit_q == LAST_BIT);
    assign tx_busy  = (state_q == ST_TX_HI) || (state_q == ST_TX_LO);
    assign rx_busy  = (state_q == ST_RX_HI) || (state_q == ST_RX_LO);
    assign div_hold = (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_tx)      state_d = ST_TX_HI;
                else if (start_rx) state_d = ST_RX_HI;
            end
            ST_TX_HI: if (fall_evt) state_d = ST_TX_LO;
            ST_TX_LO: if (rise_evt) state_d = last ? ST_IDLE : ST_TX_HI;
            ST_RX_HI: if (fall_evt) state_d = ST_RX_LO;
            ST_RX_LO: if (rise_evt) state_d = last ? ST_IDLE : ST_RX_HI;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk   <= 1'b1;
            sout   <= 1'b0;
            tx_irq <= 1'b0;
            rx_irq <= 1'b0;
            bit_q  <= '0;
            data_q <= '0;
        end else begin
            tx_irq <= 1'b0;
            rx_irq <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    bit_q <= '0;
                    if (data_we) data_q <= data_wdata;
                end
                ST_TX_HI: begin
                    if (fall_evt) begin
                        sclk   <= 1'b0;
                        sout   <= data_q[0];
                        data_q <= {data_q[0], data_q[DW-1:1]};
                    end
                end
                ST_TX_LO: begin
                    if (rise_evt) begin
                        sclk <= 1'b1;
                        if (last) begin
                            tx_irq <= 1'b1;
                            bit_q  <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_RX_HI: begin
                    if (fall_evt) sclk <= 1'b0;
                end
                ST_RX_LO: begin
                    if (rise_evt) begin
                        sclk   <= 1'b1;
                        data_q <= {sin, data_q[DW-1:1]};
                        if (last) begin
                            rx_irq <= 1'b1;
                            bit_q  <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: begin
                    sclk <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/ssm_top.sv
module ssm_top #(
    parameter int DW  = 8,
    parameter int DIV = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          reg_we,
    input  logic [1:0]    reg_waddr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [1:0]    reg_raddr,
    output logic [DW-1:0] reg_rdata,
    input  logic          sin_i,
    output logic          sclk_o,
    output logic          sout_o,
    output logic          tx_irq_o,
    output logic          rx_irq_o
);
    logic          start_tx;
    logic          start_rx;
    logic          data_we;
    logic          tx_busy;
    logic          rx_busy;
    logic          div_hold;
    logic          fall_evt;
    logic          rise_evt;
    logic [DW-1:0] data_q;

    ssm_regif #(.DW(DW)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .waddr    (reg_waddr),
        .wdata    (reg_wdata),
        .raddr    (reg_raddr),
        .rdata    (reg_rdata),
        .tx_busy  (tx_busy),
        .rx_busy  (rx_busy),
        .data_q   (data_q),
        .start_tx (start_tx),
        .start_rx (start_rx),
        .data_we  (data_we)
    );

    ssm_clkdiv #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (div_hold),
        .tick     (tick_i),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt)
    );

    ssm_engine #(.DW(DW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_tx   (start_tx),
        .start_rx   (start_rx),
        .fall_evt   (fall_evt),
        .rise_evt   (rise_evt),
        .sin        (sin_i),
        .data_we    (data_we),
        .data_wdata (reg_wdata),
        .data_q     (data_q),
        .tx_busy    (tx_busy),
        .rx_busy    (rx_busy),
        .div_hold   (div_hold),
        .sclk       (sclk_o),
        .sout       (sout_o),
        .tx_irq     (tx_irq_o),
        .rx_irq     (rx_irq_o)
    );

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic sclk_o,
    input logic sout_o,
    input logic tx_irq_o,
    input logic rx_irq_o,
    input logic tx_busy,
    input logic rx_busy
);

    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !rx_busy) |-> sclk_o);

    a_r3_sclk_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_o) |-> $past(tick_i));

    a_r4_sout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sout_o) |-> $fell(sclk_o));

    a_r5_tx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq_o |=> !tx_irq_o);

    a_r5_tx_irq_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq_o |-> (!tx_busy && $past(tx_busy) && $rose(sclk_o)));

    a_r6_rx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |=> !rx_irq_o);

    a_r6_rx_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> (!rx_busy && $past(rx_busy) && $rose(sclk_o)));

    a_r9_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && rx_busy));

endmodule

bind ssm_top ssm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .sclk_o   (sclk_o),
    .sout_o   (sout_o),
    .tx_irq_o (tx_irq_o),
    .rx_irq_o (rx_irq_o),
    .tx_busy  (tx_busy),
    .rx_busy  (rx_busy)
);

// File: tb/sim_ssm_top.sv
`timescale 1ns/1ps
module sim_ssm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_waddr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] reg_raddr = '0;
    logic [7:0] reg_rdata;
    logic       sin_i = 1'b0;
    logic       sclk_o, sout_o, tx_irq_o, rx_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ssm_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .sin_i(sin_i), .sclk_o(sclk_o), .sout_o(sout_o),
        .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 sclk", sclk_o, 1);
        chk("R1 sout", sout_o, 0);
        chk("R1 irqs", {tx_irq_o, rx_irq_o}, 0);
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 trig", v, 0);
        rd(2'd2, v); chk("R1 data", v, 0);
        rd(2'd3, v); chk("R2 unmapped", v, 0);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h5A);
        wr(2'd1, 8'h03);
        rd(2'd1, v); chk("R2 trig ignored when disabled", v, 0);
        for (int k = 0; k < 20; k++) tick_once();
        chk("R2 sclk idle when disabled", sclk_o, 1);
        rd(2'd2, v); chk("R2 data written", v, 8'h5A);
    endtask

    // trigval: value written to the trigger register; meddle: writes mid-transfer
    task automatic t_tx(input logic [7:0] b, input logic [7:0] trigval, input bit meddle);
        logic [7:0] v;
        int bad_clk = 0, bad_bit = 0, bad_irq = 0, bad_busy = 0;
        wr(2'd2, b);
        wr(2'd1, trigval);
        rd(2'd1, v); chk("R7 R9 tx busy only", v, 1);
        chk("R3 sclk high at start", sclk_o, 1);
        for (int k = 1; k <= 128; k++) begin
            if (meddle && k == 40) begin
                wr(2'd2, 8'hFF);
                wr(2'd1, 8'h02);
                wr(2'd1, 8'h01);
            end
            tick_once();
            if (sclk_o != (((k % 16) >= 8) ? 1'b0 : 1'b1)) bad_clk++;
            if ((k % 16) == 8 && sout_o != b[(k - 8) / 16]) bad_bit++;
            if (tx_irq_o != (k == 128) || rx_irq_o) bad_irq++;
            rd(2'd1, v);
            if (v != ((k == 128) ? 8'h00 : 8'h01)) bad_busy++;
        end
        chk("R3 sclk waveform", bad_clk, 0);
        chk("R4 tx bits lsb first", bad_bit, 0);
        chk("R5 tx irq timing", bad_irq, 0);
        chk("R7 tx busy readback", bad_busy, 0);
        @(negedge clk);
        chk("R5 tx irq one cycle", tx_irq_o, 0);
        rd(2'd2, v); chk(meddle ? "R8 data unchanged" : "R5 data kept", v, b);
        rd(2'd1, v); chk(meddle ? "R8 no rx started" : "R5 trig clear", v, 0);
        for (int k = 0; k < 24; k++) tick_once();
        chk("R10 sout holds last bit", sout_o, b[7]);
        chk("R11 sclk idle after ticks", sclk_o, 1);
    endtask

    task automatic t_rx(input logic [7:0] b);
        logic [7:0] v;
        int bad_clk = 0, bad_irq = 0, bad_busy = 0;
        logic hold_out;
        hold_out = sout_o;
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R7 rx busy", v, 2);
        for (int k = 1; k <= 128; k++) begin
            if ((k - 1) % 16 == 0) sin_i = b[(k - 1) / 16];
            tick_once();
            if (sclk_o != (((k % 16) >= 8) ? 1'b0 : 1'b1)) bad_clk++;
            if (rx_irq_o != (k == 128) || tx_irq_o) bad_irq++;
            rd(2'd1, v);
            if (v != ((k == 128) ? 8'h00 : 8'h02)) bad_busy++;
            if (k == 128) begin
                rd(2'd2, v); chk("R6 rx data at irq", v, b);
            end
        end
        chk("R3 rx sclk waveform", bad_clk, 0);
        chk("R6 rx irq timing", bad_irq, 0);
        chk("R7 rx busy readback", bad_busy, 0);
        chk("R10 sout untouched by rx", sout_o, hold_out);
        @(negedge clk);
        chk("R6 rx irq one cycle", rx_irq_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        wr(2'd0, 8'h01);
        t_tx(8'hA5, 8'h01, 1'b0);
        t_tx(8'h3C, 8'h01, 1'b0);
        wr(2'd0, 8'h03);
        t_tx(8'h81, 8'h01, 1'b1);
        t_tx(8'h96, 8'h03, 1'b0);
        t_rx(8'h6B);
        t_rx(8'hD2);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule